// File: doc/BRIEF.md
# Prioritized Interrupt Request Controller

This block gathers interrupt requests from a set of sources, for example edge detectors on external pins or underflow pulses from timers. Each source owns a request latch and an enable bit that software can write. A one-cycle pulse on a source's event line sets its latch. The latch holds its value until the request is accepted or software clears it.

The CPU marks the instants at which an interrupt may be taken by raising `accept_point`, normally once per instruction boundary. It also presents its global interrupt-disable flag on `cpu_irq_mask`. At such an instant, if the flag is clear, the controller looks at every source whose latch and enable bit are both set and accepts the one with the lowest index. On the following cycle it pulses `take`, presents the winner's index and its vector address, and raises `set_mask` so that the CPU sets its disable flag and blocks nesting. The accepted source's latch is cleared automatically. Latches that lost the arbitration, or were masked, stay set and compete again at the next acceptance point.

Software reaches the latches and enables through a one-word register port. `reg_sel` = 0 selects the request latches. A write there can only clear bits: a 0 clears, a 1 leaves the bit alone. `reg_sel` = 1 selects the enable bits, which a write loads directly. `reg_rdata` returns the selected word combinationally.

Top module: `prio_irq_ctrl`

## Requirements
- R1: An event pulse on source i sets request bit i. The bit then stays at 1 across later cycles until it is accepted or cleared by a software write.
- R2: A request can be accepted only when its request bit is 1, its enable bit is 1, and `cpu_irq_mask` is 0. If no source meets all three, `take` stays 0.
- R3: Acceptance is decided only in a cycle with `accept_point` = 1. Eligible requests pending in other cycles produce no `take`.
- R4: When several sources are eligible at one acceptance point, the one with the lowest index wins, and `irq_idx` reports that index.
- R5: Request bits of sources that were not accepted keep their values after the acceptance point.
- R6: An acceptance decided in cycle t gives `take` = 1 and `set_mask` = 1 in cycle t+1 only. In that same cycle the winner's request bit reads back 0.
- R7: While `take` is 1, `irq_vec` equals VEC_BASE − 2·`irq_idx`, the low byte of a low/high byte pair.
- R8: If a source event and a software clear of that source's request bit fall in the same clock, the bit ends at 1.
- R9: A request that is pending but disabled stays latched through acceptance points. It becomes eligible at the first acceptance point after its enable bit is set.
- R10: After reset, all request bits and enable bits read 0, and `take` and `set_mask` are 0.
- R11: Writing 1 to a request bit through the register port (`reg_sel` = 0) does not set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_event | input | NUM_SRC | One-cycle request pulses, one per source |
| accept_point | input | 1 | CPU acceptance instant (instruction boundary) |
| cpu_irq_mask | input | 1 | CPU global interrupt-disable flag |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = request latches, 1 = enable bits |
| reg_wdata | input | NUM_SRC | Register write data |
| reg_rdata | output | NUM_SRC | Selected register contents |
| take | output | 1 | Accept strobe, one cycle |
| irq_idx | output | IDX_W | Index of the accepted source |
| irq_vec | output | VEC_W | Vector address of the accepted source |
| set_mask | output | 1 | Tells the CPU to set its disable flag |

## Verification
The hardest condition to reach from the ports is a fully populated arbitration: every mix of pending requests, enables and the mask flag at one acceptance point. The bench sweeps all request patterns against all enable patterns, with the mask both clear and set, on a four-source build. Before each point it clears the latches and reloads the enables through the register port. It then predicts the winner arithmetically and reads back the surviving latches. Directed sequences cover the same-cycle race between an event and a clear, and a masked request that is enabled later.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic {
    SEL_REQ = 1'b0,
    SEL_EN  = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/irq_req_bank.sv
module irq_req_bank #(
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic [NUM_SRC-1:0] sw_clr_i,
  input  logic [NUM_SRC-1:0] acc_clr_i,
  output logic [NUM_SRC-1:0] req_o
);
  logic [NUM_SRC-1:0] req_q;
  logic [NUM_SRC-1:0] req_d;

  // a set in the same cycle as any clear wins
  always_comb begin
    req_d = (req_q & ~(sw_clr_i | acc_clr_i)) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= '0;
    else        req_q <= req_d;
  end

  assign req_o = req_q;
endmodule

// File: rtl/irq_en_reg.sv
module irq_en_reg #(
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic [NUM_SRC-1:0] data_i,
  output logic [NUM_SRC-1:0] en_o
);
  logic [NUM_SRC-1:0] en_q;
  logic [NUM_SRC-1:0] en_d;

  always_comb begin
    en_d = en_q;
    if (load_i) en_d = data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_d;
  end

  assign en_o = en_q;
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int NUM_SRC = 8,
  parameter int IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0] elig_i,
  output logic [NUM_SRC-1:0] grant_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic               any_o
);
  logic [NUM_SRC:0] blocked;

  assign blocked[0] = 1'b0;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_SRC; gi++) begin : g_chain
      assign grant_o[gi]    = elig_i[gi] & ~blocked[gi];
      assign blocked[gi+1]  = blocked[gi] | elig_i[gi];
    end
  endgenerate

  assign any_o = blocked[NUM_SRC];

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (grant_o[i]) idx_o = idx_o | IDX_W'(i);
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int          NUM_SRC  = 8,
  parameter int          VEC_W    = 16,
  parameter logic [15:0] VEC_BASE = 16'hFFFC,
  parameter int          IDX_W    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_event,
  input  logic               accept_point,
  input  logic               cpu_irq_mask,
  input  logic               reg_wr,
  input  logic               reg_sel,
  input  logic [NUM_SRC-1:0] reg_wdata,
  output logic [NUM_SRC-1:0] reg_rdata,
  output logic               take,
  output logic [IDX_W-1:0]   irq_idx,
  output logic [VEC_W-1:0]   irq_vec,
  output logic               set_mask
);
  import irq_pkg::*;

  localparam logic [VEC_W-1:0] BASE_W = VEC_W'(VEC_BASE);

  reg_sel_e           sel;
  logic [NUM_SRC-1:0] req;
  logic [NUM_SRC-1:0] en;
  logic [NUM_SRC-1:0] elig;
  logic [NUM_SRC-1:0] grant;
  logic [NUM_SRC-1:0] sw_clr;
  logic [NUM_SRC-1:0] acc_clr;
  logic [IDX_W-1:0]   pick_idx;
  logic               pick_any;
  logic               fire;

  logic               take_q,  take_d;
  logic [IDX_W-1:0]   idx_q,   idx_d;
  logic [VEC_W-1:0]   vec_q,   vec_d;

  assign sel    = reg_sel_e'(reg_sel);
  assign sw_clr = (reg_wr && sel == SEL_REQ) ? ~reg_wdata : '0;
  assign elig   = req & en;
  assign fire   = accept_point & ~cpu_irq_mask & pick_any;
  assign acc_clr = fire ? grant : '0;

  irq_req_bank #(.NUM_SRC(NUM_SRC)) u_req (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_i     (src_event),
    .sw_clr_i  (sw_clr),
    .acc_clr_i (acc_clr),
    .req_o     (req)
  );

  irq_en_reg #(.NUM_SRC(NUM_SRC)) u_en (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (reg_wr && sel == SEL_EN),
    .data_i (reg_wdata),
    .en_o   (en)
  );

  irq_prio_pick #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_pick (
    .elig_i  (elig),
    .grant_o (grant),
    .idx_o   (pick_idx),
    .any_o   (pick_any)
  );

  always_comb begin
    take_d = fire;
    idx_d  = idx_q;
    vec_d  = vec_q;
    if (fire) begin
      idx_d = pick_idx;
      vec_d = BASE_W - (VEC_W'(pick_idx) << 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_q <= 1'b0;
      idx_q  <= '0;
      vec_q  <= '0;
    end else begin
      take_q <= take_d;
      idx_q  <= idx_d;
      vec_q  <= vec_d;
    end
  end

  assign reg_rdata = (sel == SEL_EN) ? en : req;
  assign take      = take_q;
  assign set_mask  = take_q;
  assign irq_idx   = idx_q;
  assign irq_vec   = vec_q;
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
  parameter int          NUM_SRC  = 8,
  parameter int          VEC_W    = 16,
  parameter logic [15:0] VEC_BASE = 16'hFFFC,
  parameter int          IDX_W    = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] src_event,
  input logic               accept_point,
  input logic               cpu_irq_mask,
  input logic               reg_wr,
  input logic               reg_sel,
  input logic [NUM_SRC-1:0] req,
  input logic [NUM_SRC-1:0] en,
  input logic               take,
  input logic [IDX_W-1:0]   irq_idx,
  input logic [VEC_W-1:0]   irq_vec
);
  // R1
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept_point && !(reg_wr && !reg_sel)) |=> ((req & $past(req)) == $past(req)));

  // R2
  no_ineligible_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(accept_point && !cpu_irq_mask && (req & en) != '0) |=> !take);

  // R3
  take_follows_point_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_point && !cpu_irq_mask && (req & en) != '0) |=> take);

  // R4
  lowest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> ((($past(req & en) >> irq_idx) & 1) == 1 &&
              ($past(req & en) & ((NUM_SRC'(1) << irq_idx) - 1)) == '0));

  // R6
  winner_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (((req >> irq_idx) & 1) == 0 || (($past(src_event) >> irq_idx) & 1) == 1));

  // R7
  vec_relation_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> irq_vec == VEC_W'(VEC_BASE) - (VEC_W'(irq_idx) << 1));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(
  .NUM_SRC(NUM_SRC), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .src_event(src_event), .accept_point(accept_point),
  .cpu_irq_mask(cpu_irq_mask), .reg_wr(reg_wr), .reg_sel(reg_sel),
  .req(req), .en(en), .take(take), .irq_idx(irq_idx), .irq_vec(irq_vec)
);

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
  localparam int N    = 4;
  localparam int IW   = 2;
  localparam int VW   = 16;
  localparam logic [15:0] BASE = 16'hFFFC;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  src_event;
  logic          accept_point, cpu_irq_mask, reg_wr, reg_sel;
  logic [N-1:0]  reg_wdata, reg_rdata;
  logic          take, set_mask;
  logic [IW-1:0] irq_idx;
  logic [VW-1:0] irq_vec;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  prio_irq_ctrl #(.NUM_SRC(N), .VEC_W(VW), .VEC_BASE(BASE)) u_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .src_event(src_event), .accept_point(accept_point),
    .cpu_irq_mask(cpu_irq_mask), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .take(take),
    .irq_idx(irq_idx), .irq_vec(irq_vec), .set_mask(set_mask)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic s, output logic [N-1:0] v);
    reg_sel = s;
    #0.5;
    v = reg_rdata;
  endtask

  task automatic wr(input logic s, input logic [N-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_sel = 1'b0;
  endtask

  task automatic pulse_ev(input logic [N-1:0] p);
    @(negedge clk);
    src_event = p;
    @(negedge clk);
    src_event = '0;
  endtask

  task automatic point(input logic m);
    accept_point = 1'b1; cpu_irq_mask = m;
    @(negedge clk);
    accept_point = 1'b0; cpu_irq_mask = 1'b0;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [N-1:0] v;
    rst_n = 1'b0; src_event = '0; accept_point = 1'b0; cpu_irq_mask = 1'b0;
    reg_wr = 1'b0; reg_sel = 1'b0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    rd(1'b0, v); chk("R10 req", 32'(v), 0);
    rd(1'b1, v); chk("R10 en", 32'(v), 0);
    chk("R10 take", 32'(take), 0);
    chk("R10 set_mask", 32'(set_mask), 0);

    // R11 writing ones to request does not set
    wr(1'b0, 4'hF);
    rd(1'b0, v); chk("R11 req after write ones", 32'(v), 0);

    // R1 latch persistence, R3 no take without point
    wr(1'b1, 4'hF);
    pulse_ev(4'b0100);
    repeat (5) begin
      @(negedge clk);
      chk("R3 no take off-point", 32'(take), 0);
    end
    rd(1'b0, v); chk("R1 latch held", 32'(v), 32'h4);

    // R8 event and software clear in same clock
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = '0; src_event = 4'b0100;
    @(negedge clk);
    reg_wr = 1'b0; src_event = '0;
    rd(1'b0, v); chk("R8 event beats clear", 32'(v), 32'h4);

    // R9 disabled pending stays, then accepted after enable
    wr(1'b1, 4'b0000);
    point(1'b0);
    chk("R9 no take while disabled", 32'(take), 0);
    rd(1'b0, v); chk("R9 still latched", 32'(v), 32'h4);
    wr(1'b1, 4'b0100);
    point(1'b0);
    chk("R9 take after enable", 32'(take), 1);
    chk("R9 idx", 32'(irq_idx), 2);

    // exhaustive sweep: R2 R4 R5 R6 R7
    for (int m = 0; m < 2; m++) begin
      for (int r = 0; r < 16; r++) begin
        for (int e = 0; e < 16; e++) begin
          logic [N-1:0] el;
          logic         exp_take;
          int           exp_idx;
          logic [N-1:0] exp_req;
          wr(1'b0, '0);
          wr(1'b1, N'(e));
          pulse_ev(N'(r));
          point(m[0]);
          el = N'(r) & N'(e);
          exp_take = (m == 0) && (el != '0);
          exp_idx = 0;
          for (int k = N - 1; k >= 0; k--) if (el[k]) exp_idx = k;
          exp_req = N'(r);
          if (exp_take) exp_req[exp_idx] = 1'b0;
          chk("R2 take", 32'(take), 32'(exp_take));
          chk("R6 set_mask", 32'(set_mask), 32'(exp_take));
          if (exp_take) begin
            chk("R4 idx", 32'(irq_idx), 32'(exp_idx));
            chk("R7 vec", 32'(irq_vec), 32'(16'(BASE - 16'(2 * exp_idx))));
          end
          rd(1'b0, v); chk("R5 req after point", 32'(v), 32'(exp_req));
          @(negedge clk);
          chk("R6 one-cycle take", 32'(take), 0);
        end
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule